// File: doc/BRIEF.md
# Freeze-capable synchronous binary clock divider

This block derives three slower clocks from one input clock. The three outputs run at one half, one quarter and one eighth of the input rate. All three are bits of a single counter that advances on the rising input edge, so wherever two outputs switch in the same cycle they switch on the same edge. The outputs come straight from flops and cannot glitch.

A hold input stops the divider and keeps its current phase. A flop clocked on the falling input edge samples the hold input, so the permission to count can only change while the input clock is low. A count never starts or stops part-way through a high phase, and the divider resumes from the phase it was held at.

A master reset clears the divider at once, without waiting for a clock edge. When reset is released, two falling-edge stages pass the release on before counting restarts. The number of rising edges before the first output change therefore depends on the clock level at the moment of release. This fixed rule lets several dividers released by the same reset stay in step with each other.

Top module: `freeze_clk_divider`

## Requirements
- R1: While counting, q_div2 has a period of 2 input clocks, q_div4 a period of 4 and q_div8 a period of 8. Reading {q_div8,q_div4,q_div2} as a 3-bit number, it decreases by one, modulo 8, on every counted rising edge.
- R2: q_div4 changes only on a rising edge of q_div2, and q_div8 changes only on a rising edge of q_div4. The first counted edge after reset drives all three outputs from 0 to 1 together.
- R3: While mr is high, all three outputs are 0. They are cleared without waiting for a clock edge.
- R4: If mr falls while clk is high, the first output change occurs on the 2nd rising clk edge after the release.
- R5: If mr falls while clk is low, the first output change occurs on the 3rd rising clk edge after the release.
- R6: en is sampled on falling clk edges. A rising edge that follows a falling edge at which en was high does not change the outputs. If en rises while clk is high, the very next rising edge is already held. If en rises while clk is low, one more rising edge still counts.
- R7: After en goes low, counting resumes on the first rising edge that follows a falling edge at which en was low. Counting continues from the held value, with no state skipped or repeated.
- R8: While mr stays low, no high or low phase of any output is shorter than one input clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| en | input | 1 | Hold request, active high, sampled on the falling clk edge |
| mr | input | 1 | Master reset, active high, clears the divider asynchronously |
| q_div2 | output | 1 | Input clock divided by 2 |
| q_div4 | output | 1 | Input clock divided by 4 |
| q_div8 | output | 1 | Input clock divided by 8 |

## Verification
The assertions check on every cycle that the outputs hold whenever counting is not permitted and step down by exactly one when it is. They also check that each slower output changes only on a rising edge of the next faster one, and that the outputs read zero during reset. Only the bench scenarios can show the edge counts after reset release in each clock phase and the one-edge difference between raising or lowering en in the high and low phases. Only the bench can measure the output periods and minimum pulse widths. Its reference model is compared every cycle through a long sweep that toggles en and pulses mr in both clock phases.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // number of binary divider stages (div2, div4, div8)
  localparam int DIV_STAGES = 3;
  typedef logic [DIV_STAGES-1:0] div_word_t;
endpackage

// File: rtl/fall_capture.sv
`timescale 1ns/1ps
// Falling-edge sampling flop with asynchronous clear.
module fall_capture #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(negedge clk or posedge clr) begin
    if (clr) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/release_sync.sv
`timescale 1ns/1ps
// Passes the release of the clear through DEPTH falling-edge stages.
module release_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic clr,
  output logic ready
);
  logic [DEPTH-1:0] stage;

  always_ff @(negedge clk or posedge clr) begin
    if (clr) stage <= '0;
    else     stage <= (stage << 1) | DEPTH'(1);
  end

  assign ready = stage[DEPTH-1];
endmodule

// File: rtl/div_chain.sv
`timescale 1ns/1ps
// Down-counting toggle chain: bit i toggles when all lower bits are zero.
module div_chain #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              adv,
  output logic [STAGES-1:0] cnt
);
  logic [STAGES:0] tgl;

  assign tgl[0] = adv;

  for (genvar i = 0; i < STAGES; i++) begin : g_bit
    assign tgl[i+1] = tgl[i] & ~cnt[i];

    always_ff @(posedge clk or posedge clr) begin
      if (clr)         cnt[i] <= 1'b0;
      else if (tgl[i]) cnt[i] <= ~cnt[i];
    end
  end
endmodule

// File: rtl/freeze_clk_divider.sv
`timescale 1ns/1ps
module freeze_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int RELEASE_STAGES = 2
) (
  input  logic clk,
  input  logic en,
  input  logic mr,
  output logic q_div2,
  output logic q_div4,
  output logic q_div8
);
  logic      en_held;
  logic      run_ok;
  logic      advance;
  div_word_t count;

  // hold request sampled while clk falls, so permission changes only in the low phase
  fall_capture #(.WIDTH(1)) u_hold (
    .clk (clk),
    .clr (mr),
    .d   (en),
    .q   (en_held)
  );

  release_sync #(.DEPTH(RELEASE_STAGES)) u_release (
    .clk   (clk),
    .clr   (mr),
    .ready (run_ok)
  );

  assign advance = run_ok & ~en_held;

  div_chain #(.STAGES(DIV_STAGES)) u_chain (
    .clk (clk),
    .clr (mr),
    .adv (advance),
    .cnt (count)
  );

  assign q_div2 = count[0];
  assign q_div4 = count[1];
  assign q_div8 = count[2];
endmodule

// File: rtl/freeze_clk_divider_chk.sv
`timescale 1ns/1ps
module freeze_clk_divider_chk (
  input logic clk,
  input logic mr,
  input logic en_held,
  input logic run_ok,
  input logic q_div2,
  input logic q_div4,
  input logic q_div8
);
  logic [2:0] word;
  assign word = {q_div8, q_div4, q_div2};

  // R3: outputs are zero whenever reset is active
  always @(negedge clk) begin
    if (mr) begin
      p_clear_r3: assert (word == 3'd0);
    end
  end

  // R6: no count when held or not yet released
  p_hold_r6: assert property (@(posedge clk) disable iff (mr)
    (en_held || !run_ok) |=> $stable(word));

  // R1: a counted edge steps the value down by one
  p_step_r1: assert property (@(posedge clk) disable iff (mr)
    (run_ok && !en_held) |=> (word == $past(word) - 3'd1));

  // R2: q_div4 changes only with a rising q_div2
  p_align4_r2: assert property (@(posedge clk) disable iff (mr)
    !$stable(q_div4) |-> $rose(q_div2));

  // R2: q_div8 changes only with a rising q_div4
  p_align8_r2: assert property (@(posedge clk) disable iff (mr)
    !$stable(q_div8) |-> $rose(q_div4));
endmodule

bind freeze_clk_divider freeze_clk_divider_chk u_chk (
  .clk     (clk),
  .mr      (mr),
  .en_held (en_held),
  .run_ok  (run_ok),
  .q_div2  (q_div2),
  .q_div4  (q_div4),
  .q_div8  (q_div8)
);

// File: tb/tb_freeze_clk_divider.sv
`timescale 1ns/1ps
module tb_freeze_clk_divider;
  logic clk = 1'b0;
  logic en  = 1'b0;
  logic mr  = 1'b0;
  logic q_div2, q_div4, q_div8;
  logic [2:0] qv;

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  freeze_clk_divider dut (
    .clk(clk), .en(en), .mr(mr),
    .q_div2(q_div2), .q_div4(q_div4), .q_div8(q_div8)
  );

  assign qv = {q_div8, q_div4, q_div2};

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference cycle model built from R1, R3-R7
  logic [2:0] m_val = 3'd0;
  int         m_rel = 0;
  logic       m_en  = 1'b0;

  always @(posedge clk or posedge mr) begin
    if (mr) m_val <= 3'd0;
    else if (m_rel >= 2 && !m_en) m_val <= m_val - 3'd1;
  end

  always @(negedge clk or posedge mr) begin
    if (mr) begin
      m_rel <= 0;
      m_en  <= 1'b0;
    end else begin
      m_en <= en;
      if (m_rel < 2) m_rel <= m_rel + 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !mr) check("R1/R6/R7 model", int'(qv), int'(m_val));
  end

  // R8 pulse width monitor
  logic [2:0] qprev = 3'd0;
  bit   [2:0] meas  = 3'd0;
  realtime    last_t [3];

  always @(qv or mr) begin
    for (int b = 0; b < 3; b++) begin
      if (qv[b] !== qprev[b]) begin
        if (!mr && meas[b]) begin
          n_chk++;
          if ($realtime - last_t[b] < 10.0) begin
            n_fail++;
            $display("FAIL R8 bit%0d actual=%0t expected>=10ns", b, $realtime - last_t[b]);
          end
        end
        last_t[b] = $realtime;
        meas[b]   = !mr;
      end
    end
    qprev = qv;
    if (mr) meas = 3'd0;
  end

  task automatic count_release(output int edges, output logic [2:0] first);
    edges = 0;
    first = 3'd0;
    for (int i = 1; i <= 5; i++) begin
      @(posedge clk); #1;
      if (qv != 3'd0 && edges == 0) begin
        edges = i;
        first = qv;
      end
    end
  endtask

  initial begin
    #500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int         edges;
    logic [2:0] first, v;
    realtime    t0, t1;
    logic [15:0] lfsr;

    mr = 1'b1;
    repeat (3) @(negedge clk);
    #2 check("R3 reset state", int'(qv), 0);
    cmp_on = 1'b1;

    // R4: release while clk high
    @(posedge clk); #2 mr = 1'b0;
    count_release(edges, first);
    check("R4 edges after high-phase release", edges, 2);
    check("R2 first count all high", int'(first), 7);

    // R1: periods
    @(posedge q_div8); t0 = $realtime; @(posedge q_div8); t1 = $realtime;
    check("R1 div8 period", int'(t1 - t0), 80);
    @(posedge q_div4); t0 = $realtime; @(posedge q_div4); t1 = $realtime;
    check("R1 div4 period", int'(t1 - t0), 40);
    @(posedge q_div2); t0 = $realtime; @(posedge q_div2); t1 = $realtime;
    check("R1 div2 period", int'(t1 - t0), 20);

    // R3: asynchronous clear mid low phase
    @(negedge clk); #2 mr = 1'b1;
    #1 check("R3 async clear", int'(qv), 0);
    repeat (3) @(posedge clk);

    // R5: release while clk low
    @(negedge clk); #2 mr = 1'b0;
    count_release(edges, first);
    check("R5 edges after low-phase release", edges, 3);

    // R6/R7 in high phase
    @(posedge clk); #2 v = qv; en = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R6 hold raised in high phase", int'(qv), int'(v));
    @(posedge clk); #2 v = qv; en = 1'b0;
    @(posedge clk); #1 check("R7 resume lowered in high phase", int'(qv), int'(3'(v - 3'd1)));
    @(posedge clk); #1 check("R7 continue", int'(qv), int'(3'(v - 3'd2)));

    // R6/R7 in low phase
    @(negedge clk); #2 v = qv; en = 1'b1;
    @(posedge clk); #1 check("R6 one more count after low-phase raise", int'(qv), int'(3'(v - 3'd1)));
    repeat (3) @(posedge clk);
    #1 check("R6 held after low-phase raise", int'(qv), int'(3'(v - 3'd1)));
    @(negedge clk); #2 v = qv; en = 1'b0;
    @(posedge clk); #1 check("R7 still held after low-phase lower", int'(qv), int'(v));
    @(posedge clk); #1 check("R7 resume after low-phase lower", int'(qv), int'(3'(v - 3'd1)));

    // sweep: en toggles and mr pulses in both phases, compared to the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) @(posedge clk);
      else         @(negedge clk);
      #2;
      if (lfsr[3:1] == 3'd0) en = ~en;
      if (lfsr[9:4] == 6'd0) begin
        mr = 1'b1;
        repeat (2) @(posedge clk);
        if (lfsr[10]) @(negedge clk);
        else          @(posedge clk);
        #2 mr = 1'b0;
      end
    end

    en = 1'b0;
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule